// File: doc/BRIEF.md
# Static Configuration Word Serializer

This block pushes a 16-bit configuration word into an always-on domain over three wires: a slow static clock, a shared data line and an enable line. Software loads the upper payload byte into a byte register, then writes the control register with the lower payload byte and a start bit set. It then polls a busy bit until the frame is complete. The hardware generates the whole framed sequence with no further software action.

A frame is 35 static-clock cycles. The first is an opening cycle with enable low. Sixteen cycles then carry a fixed key word, followed by one turnaround cycle with data held low. Sixteen cycles carry the payload, and a closing cycle drops enable again. Each static-clock cycle is a low phase followed by a high phase. The length of each phase comes from an input and is fixed for the whole frame when the frame starts.

Top module: `static_cfg_serializer`

## Requirements
- R1: After reset, and whenever no frame is running, `sclk_o`, `en_o`, `sdi_o` and `busy_o` are all low.
- R2: Register select 0 writes the byte register from write data bits [7:0], which become payload bits [15:8]. Register select 1 writes the control register, whose bits [31:24] become payload bits [7:0]. The control read view returns the last stored lower byte in [31:24] and the busy state in bit 22; all other bits read 0.
- R3: A control write with bit 17 set while idle starts a frame. `busy_o` and read bit 22 are high from the next clock until the frame ends. A control write with bit 17 clear starts nothing.
- R4: Every static-clock cycle is a low phase and then a high phase, each lasting `phase_len_i`+1 system clocks, with the value sampled at start. `en_o` and `sdi_o` change only when a low phase begins.
- R5: Static-clock cycle 0 (opening) has `en_o` low and `sdi_o` low.
- R6: Cycles 1 to 16 carry the key 0xB41B, most significant bit first, with `en_o` high.
- R7: Cycle 17 (turnaround) has `en_o` high and `sdi_o` low.
- R8: Cycles 18 to 33 carry the payload, most significant bit first, with `en_o` high.
- R9: Cycle 34 (closing) has `en_o` and `sdi_o` low. `busy_o` falls on the clock right after that cycle's high phase ends.
- R10: A start request made while busy is ignored. Register writes and changes to `phase_len_i` during a frame do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: byte register, 1: control register |
| wr_data_i | input | 32 | Register write data |
| phase_len_i | input | PHASE_W | Static clock phase length minus one, in system clocks |
| ctrl_rdata_o | output | 32 | Control register read view |
| busy_o | output | 1 | Frame in progress |
| sclk_o | output | 1 | Static clock |
| en_o | output | 1 | Enable line |
| sdi_o | output | 1 | Serial data line |

## Verification
A bit index or shift register that is off by one shows up on `sdi_o` in the first key cycle. That is within two phases of the start, because the key opens with a 1 followed by a 0. A wrong phase counter shifts the next `sclk_o` edge away from the expected clock, so the per-clock comparison catches it at once. A wrong closing decision shows as a busy bit that falls early or late, or as enable high in the closing cycle. Starts attempted mid-frame and on the last busy clock show whether busy gates the start request.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_WORD = 16'hB41B;
  localparam int PAY_W = 16;
  localparam int WORD_W = KEY_W + PAY_W;
  // opening + key + turnaround + payload + closing
  localparam int FRAME_CYC = KEY_W + PAY_W + 3;
  localparam int IDX_W = $clog2(FRAME_CYC);
  localparam int CTRL_START_BIT = 17;
  localparam int CTRL_BUSY_BIT = 22;
  localparam int CTRL_LO_LSB = 24;

  typedef enum logic {
    REG_HIBYTE = 1'b0,
    REG_CTRL   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/scfg_regs.sv
module scfg_regs
  import scfg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_sel_i,
  input  logic [31:0]          wr_data_i,
  input  logic                 busy_i,
  output logic                 start_o,
  output logic [PAY_W-1:0]     payload_o,
  output logic [31:0]          rdata_o
);
  logic [7:0] hi_byte_q, lo_byte_q;
  logic       ctrl_wr;
  logic       unused_wdata;

  assign ctrl_wr = wr_en_i && (reg_sel_e'(wr_sel_i) == REG_CTRL);
  assign unused_wdata = ^{wr_data_i[23:18], wr_data_i[16:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_byte_q <= '0;
      lo_byte_q <= '0;
    end else if (wr_en_i) begin
      if (ctrl_wr) lo_byte_q <= wr_data_i[CTRL_LO_LSB +: 8];
      else         hi_byte_q <= wr_data_i[7:0];
    end
  end

  // lower byte taken straight from the bus so the start write carries it
  assign start_o   = ctrl_wr && wr_data_i[CTRL_START_BIT] && !busy_i;
  assign payload_o = {hi_byte_q, wr_data_i[CTRL_LO_LSB +: 8]};

  always_comb begin
    rdata_o = '0;
    rdata_o[CTRL_LO_LSB +: 8] = lo_byte_q;
    rdata_o[CTRL_BUSY_BIT]    = busy_i;
  end
endmodule

// File: rtl/scfg_phase_timer.sv
module scfg_phase_timer #(
  parameter int PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] len_i,
  output logic               tick_o
);
  logic [PHASE_W-1:0] len_q, cnt_q;

  assign tick_o = run_i && (cnt_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      len_q <= len_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scfg_frame_seq.sv
module scfg_frame_seq
  import scfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             en_o,
  output logic             sdi_o
);
  localparam logic [IDX_W-1:0] IDX_OPEN  = '0;
  localparam logic [IDX_W-1:0] IDX_TURN  = IDX_W'(KEY_W + 1);
  localparam logic [IDX_W-1:0] IDX_CLOSE = IDX_W'(FRAME_CYC - 1);

  logic              busy_q, hi_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] sh_q;
  logic              data_cyc;

  assign data_cyc = (idx_q != IDX_OPEN) && (idx_q != IDX_TURN) && (idx_q != IDX_CLOSE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      hi_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= {KEY_WORD, payload_i};
    end else if (busy_q && tick_i) begin
      if (!hi_q) begin
        hi_q <= 1'b1;
      end else begin
        hi_q <= 1'b0;
        if (idx_q == IDX_CLOSE) busy_q <= 1'b0;
        else                    idx_q  <= idx_q + 1'b1;
        if (data_cyc) sh_q <= sh_q << 1;
      end
    end
  end

  assign busy_o = busy_q;
  assign sclk_o = busy_q && hi_q;
  assign en_o   = busy_q && (idx_q != IDX_OPEN) && (idx_q != IDX_CLOSE);
  assign sdi_o  = busy_q && data_cyc && sh_q[WORD_W-1];
endmodule

// File: rtl/static_cfg_serializer.sv
module static_cfg_serializer
  import scfg_pkg::*;
#(
  parameter int PHASE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [31:0]        wr_data_i,
  input  logic [PHASE_W-1:0] phase_len_i,
  output logic [31:0]        ctrl_rdata_o,
  output logic               busy_o,
  output logic               sclk_o,
  output logic               en_o,
  output logic               sdi_o
);
  logic             start;
  logic             tick;
  logic             busy;
  logic [PAY_W-1:0] payload;

  scfg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .busy_i    (busy),
    .start_o   (start),
    .payload_o (payload),
    .rdata_o   (ctrl_rdata_o)
  );

  scfg_phase_timer #(.PHASE_W(PHASE_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (busy),
    .len_i   (phase_len_i),
    .tick_o  (tick)
  );

  scfg_frame_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .payload_i (payload),
    .tick_i    (tick),
    .busy_o    (busy),
    .sclk_o    (sclk_o),
    .en_o      (en_o),
    .sdi_o     (sdi_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic        busy_o,
  input logic        sclk_o,
  input logic        en_o,
  input logic        sdi_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !en_o && !sdi_o));

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && wr_data_i[17] && !busy_o) |=> (busy_o && !sclk_o));

  p_data_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> ($stable(sdi_o) && $stable(en_o)));

  p_open_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!en_o && !sdi_o));

  p_close_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(sclk_o) && !$past(en_o)));
endmodule

bind static_cfg_serializer scfg_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .busy_o    (busy_o),
  .sclk_o    (sclk_o),
  .en_o      (en_o),
  .sdi_o     (sdi_o)
);

// File: tb/static_cfg_serializer_tb.sv
module static_cfg_serializer_tb;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [PW-1:0] phase_len = '0;
  logic [31:0]   ctrl_rdata;
  logic          busy, sclk, en, sdi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    bit    sclk;
    bit    en;
    bit    sdi;
    bit    busy;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  bit   cur_busy = 0;
  logic [7:0] hi_m = '0;
  logic [7:0] lo_m = '0;

  always #2.5 clk = ~clk;

  static_cfg_serializer #(.PHASE_W(PW)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .phase_len_i  (phase_len),
    .ctrl_rdata_o (ctrl_rdata),
    .busy_o       (busy),
    .sclk_o       (sclk),
    .en_o         (en),
    .sdi_o        (sdi)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // R5 opening, R6 key, R7 turnaround, R8 payload, R9 closing
  task automatic push_frame(logic [15:0] pay, int len);
    logic [31:0] word;
    word = {16'hB41B, pay};
    for (int c = 0; c < 35; c++) begin
      exp_t e;
      e.busy = 1;
      if (c == 0)       begin e.en = 0; e.sdi = 0; e.tag = "R5"; end
      else if (c <= 16) begin e.en = 1; e.sdi = word[31-(c-1)]; e.tag = "R6"; end
      else if (c == 17) begin e.en = 1; e.sdi = 0; e.tag = "R7"; end
      else if (c <= 33) begin e.en = 1; e.sdi = word[31-(c-2)]; e.tag = "R8"; end
      else              begin e.en = 0; e.sdi = 0; e.tag = "R9"; end
      for (int p = 0; p < 2 * len; p++) begin
        e.sclk = (p >= len);
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic compare();
    exp_t e;
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else begin e.sclk = 0; e.en = 0; e.sdi = 0; e.busy = 0; e.tag = "R1"; end
    cur_busy = e.busy;
    chk("R4", "sclk", {31'd0, sclk}, {31'd0, e.sclk});
    chk(e.tag, "en", {31'd0, en}, {31'd0, e.en});
    chk(e.tag, "sdi", {31'd0, sdi}, {31'd0, e.sdi});
    chk("R3", "busy", {31'd0, busy}, {31'd0, e.busy});
    chk("R2", "ctrl_view", ctrl_rdata, {lo_m, 1'b0, e.busy, 22'd0});
  endtask

  task automatic tick(bit we, bit sel, logic [31:0] d);
    @(negedge clk);
    compare();
    wr_en = we; wr_sel = sel; wr_data = d;
    if (we) begin
      if (sel) begin
        if (d[17] && !cur_busy) push_frame({hi_m, d[31:24]}, int'(phase_len) + 1);
        lo_m = d[31:24];
      end else begin
        hi_m = d[7:0];
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 32'd0);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) tick(0, 0, 32'd0);
    idle(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 200000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);                                   // R1 reset state
    tick(1, 0, 32'h0000_00A5);                 // R2 upper byte
    tick(1, 1, 32'h3C00_0000);                 // R3 no start bit
    idle(3);
    phase_len = 0;
    tick(1, 1, 32'h3C02_0000);                 // R3 start, payload A53C
    idle(9);
    tick(1, 1, 32'hFF02_0000);                 // R10 start while busy
    tick(1, 0, 32'h0000_0011);                 // R10 byte write mid-frame
    phase_len = 3;                             // R4 captured length holds
    drain();
    phase_len = 2;
    tick(1, 0, 32'h0000_0000);
    tick(1, 1, 32'h0102_0000);                 // R8 payload 0001
    drain();
    phase_len = 1;
    tick(1, 0, 32'h0000_00FF);
    tick(1, 1, 32'hFF02_0000);                 // payload FFFF
    while (exp_q.size() > 1) tick(0, 0, 32'd0);
    tick(1, 1, 32'h0002_0000);                 // R9/R10 last busy clock: ignored
    tick(1, 1, 32'h0002_0000);                 // R3 accepted right after
    drain();
    phase_len = 4;
    tick(1, 0, 32'h0000_005A);
    tick(1, 1, 32'hC302_0000);                 // payload 5AC3
    drain();
    finish_run();
  end
endmodule